// File: doc/BRIEF.md
# Command-Framed SPI Register Access Engine

This block is an SPI master that reaches the registers of a sigma-delta converter. Every access opens with a command byte that names the direction and a 3-bit register address. Then comes a payload of one, two or three bytes, and the whole access sits inside one chip-select-low frame. Payload length depends on the register: status, ID and IO registers are 8 bits wide, mode and configuration registers are 16 bits, and the data, offset and full-scale registers are 16 or 24 bits.

A client places a request on the request port for one cycle while the engine is not busy. The engine then drives the serial frame in SPI mode 3 at a rate set by a parameter. It reports completion with a one-cycle done pulse, and read data is valid in that same cycle. A per-request hold flag keeps chip select low after the frame ends. This lets the same converter keep the bus between accesses, for example while waiting for its ready indication on the shared data line.

Top module: `adc_cmd_spi`

## Requirements
- R1: The first eight MOSI bits of a frame are the command byte, most significant bit first: bit 7 is 0, bit 6 is 1 for a read and 0 for a write, bits 5:3 hold reqAddr, and bits 2:0 are 0.
- R2: After the command byte, a write shifts out the low 8*reqSize bits of reqWdata, most significant bit first. A read holds MOSI at 0 during its payload, and MOSI is 0 whenever the engine is not busy.
- R3: For a read, the 8*reqSize bits received after the command byte appear right-aligned in rdData in the done cycle, with all higher bits 0. Bits received during the command byte have no effect. For a write or a rejected request, rdData is 0 in the done cycle.
- R4: SPI mode 3. sclk is high whenever the engine is not busy. Each bit starts with HALF_DIV cycles of sclk low, and MOSI changes only on entry to that low phase. The bit then has HALF_DIV cycles of sclk high. MISO is captured at the end of the low phase, which is the rising edge of sclk.
- R5: csN goes low in the first cycle after an accepted request and stays low for the whole frame. Unless hold was requested, csN returns high in the done cycle.
- R6: If reqHoldCs was 1 on the accepted request, csN stays low after the done cycle and through every later idle cycle until a frame without hold ends.
- R7: A request with reqSize 0 is rejected. In the next cycle done and err are both 1 for one cycle, busy stays 0, and no sclk edge or csN change occurs.
- R8: busy is 1 for exactly 2*HALF_DIV*8*(reqSize+1) cycles, starting the cycle after acceptance. done is 1 for one cycle, the cycle right after the last busy cycle.
- R9: A request presented while busy is 1 is ignored and does not change the running frame. A request presented in the done cycle is accepted.
- R10: During reset, csN and sclk are 1 and busy, done, err, mosi and rdData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is 0 |
| reqRead | input | 1 | 1 for a register read, 0 for a write |
| reqAddr | input | 3 | Register address placed in the command byte |
| reqSize | input | 2 | Payload length in bytes, 1 to 3 (0 is rejected) |
| reqWdata | input | 24 | Write payload, right-aligned |
| reqHoldCs | input | 1 | Keep chip select low after this frame |
| miso | input | 1 | Serial data from the converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set with done when the request was rejected |
| rdData | output | 24 | Read payload, right-aligned, valid with done |
| sclk | output | 1 | Serial clock, idles high |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the converter |

## Verification
All outputs are registered. csN, sclk, MOSI and busy therefore show an accepted request in the first cycle after the edge that samples it. Each bit then takes 2*HALF_DIV cycles, and done, err, rdData and the release of csN appear in the single cycle after the last high phase. A rejected request shows done and err in the cycle right after its edge. The bench builds this whole expected sequence behaviourally, one queue entry per cycle, at the moment it drives a request. It compares every output against the head of that queue at each falling clock edge, so each result is sampled in the exact cycle it is due. A serial converter model in the bench drives MISO on falling sclk edges, with non-zero bits during the command byte.

// File: rtl/adc_cmd_spi_pkg.sv
package adc_cmd_spi_pkg;

  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 3;
  localparam int PAY_W     = BYTE_W * MAX_BYTES;
  localparam int FRAME_W   = BYTE_W + PAY_W;
  localparam int BITCNT_W  = $clog2(FRAME_W);

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // latch a new request
    logic sample;  // capture miso (rising sclk)
    logic shift;   // advance the transmit register (falling sclk)
    logic finish;  // publish read data
    logic reject;  // invalid length: clear read data
  } strobe_t;

  // Command byte: bit7 zero, bit6 direction, bits5:3 address, bits2:0 zero
  function automatic logic [BYTE_W-1:0] makeCmd(input logic isRead,
                                                input logic [2:0] addr);
    return {1'b0, isRead, addr, 3'b000};
  endfunction

endpackage

// File: rtl/adc_cmd_spi_ctrl.sv
module adc_cmd_spi_ctrl
  import adc_cmd_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic       reqHoldCs,
  output strobe_t    stb,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       sclk,
  output logic       csN
);

  localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_t;

  state_t              state;
  logic [PH_W-1:0]     phase;
  logic [BITCNT_W-1:0] bitsLeft;
  logic                holdR;
  logic                sclkR;
  logic                csNR;
  logic                doneR;
  logic                errR;

  logic accept;
  logic sizeOk;
  logic lastPh;

  always_comb begin
    accept     = (state == ST_IDLE) && reqValid;
    sizeOk     = (reqSize != 2'd0);
    lastPh     = (phase == PH_LAST);
    stb.load   = accept && sizeOk;
    stb.reject = accept && !sizeOk;
    stb.sample = (state == ST_LOW) && lastPh;
    stb.shift  = (state == ST_HIGH) && lastPh && (bitsLeft != '0);
    stb.finish = (state == ST_HIGH) && lastPh && (bitsLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitsLeft <= '0;
      holdR    <= 1'b0;
      sclkR    <= 1'b1;
      csNR     <= 1'b1;
      doneR    <= 1'b0;
      errR     <= 1'b0;
    end else begin
      doneR <= 1'b0;
      errR  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (stb.load) begin
            state    <= ST_LOW;
            phase    <= '0;
            bitsLeft <= BITCNT_W'({reqSize, 3'b111});
            holdR    <= reqHoldCs;
            sclkR    <= 1'b0;
            csNR     <= 1'b0;
          end else if (stb.reject) begin
            doneR <= 1'b1;
            errR  <= 1'b1;
          end
        end
        ST_LOW: begin
          if (lastPh) begin
            sclkR <= 1'b1;
            state <= ST_HIGH;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_HIGH: begin
          if (lastPh) begin
            phase <= '0;
            if (bitsLeft == '0) begin
              state <= ST_IDLE;
              doneR <= 1'b1;
              csNR  <= !holdR;
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
              sclkR    <= 1'b0;
              state    <= ST_LOW;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;
  assign err  = errR;
  assign sclk = sclkR;
  assign csN  = csNR;

endmodule

// File: rtl/adc_cmd_spi_dp.sv
module adc_cmd_spi_dp
  import adc_cmd_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             active,
  input  logic             reqRead,
  input  logic [2:0]       reqAddr,
  input  logic [1:0]       reqSize,
  input  logic [PAY_W-1:0] reqWdata,
  input  logic             miso,
  output logic             mosi,
  output logic [PAY_W-1:0] rdData
);

  logic [FRAME_W-1:0] txShift;
  logic [PAY_W-1:0]   rxShift;
  logic [PAY_W-1:0]   rdMask;
  logic [PAY_W-1:0]   payAligned;
  logic [PAY_W-1:0]   rdDataR;
  logic [1:0]         sizeR;
  logic               readR;

  // Left-justify the payload so its first byte leaves right after the command
  always_comb begin
    payAligned = '0;
    if (!reqRead) begin
      unique case (reqSize)
        2'd1:    payAligned = {reqWdata[BYTE_W-1:0], {(PAY_W-BYTE_W){1'b0}}};
        2'd2:    payAligned = {reqWdata[2*BYTE_W-1:0], {(PAY_W-2*BYTE_W){1'b0}}};
        2'd3:    payAligned = reqWdata;
        default: payAligned = '0;
      endcase
    end
  end

  // One byte lane of the read mask per possible payload byte
  for (genvar g = 0; g < MAX_BYTES; g++) begin : gMask
    assign rdMask[g*BYTE_W +: BYTE_W] = {BYTE_W{(int'(sizeR) > g)}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdDataR <= '0;
      sizeR   <= '0;
      readR   <= 1'b0;
    end else begin
      if (stb.load) begin
        txShift <= {makeCmd(reqRead, reqAddr), payAligned};
        rxShift <= '0;
        sizeR   <= reqSize;
        readR   <= reqRead;
      end else begin
        if (stb.shift)  txShift <= {txShift[FRAME_W-2:0], 1'b0};
        if (stb.sample) rxShift <= {rxShift[PAY_W-2:0], miso};
      end
      if (stb.finish)      rdDataR <= readR ? (rxShift & rdMask) : '0;
      else if (stb.reject) rdDataR <= '0;
    end
  end

  assign mosi   = active ? txShift[FRAME_W-1] : 1'b0;
  assign rdData = rdDataR;

endmodule

// File: rtl/adc_cmd_spi.sv
module adc_cmd_spi
  import adc_cmd_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic [2:0]  reqAddr,
  input  logic [1:0]  reqSize,
  input  logic [23:0] reqWdata,
  input  logic        reqHoldCs,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [23:0] rdData,
  output logic        sclk,
  output logic        csN,
  output logic        mosi
);

  strobe_t stb;
  logic    busyI;

  adc_cmd_spi_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSize  (reqSize),
    .reqHoldCs(reqHoldCs),
    .stb      (stb),
    .busy     (busyI),
    .done     (done),
    .err      (err),
    .sclk     (sclk),
    .csN      (csN)
  );

  adc_cmd_spi_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .active  (busyI),
    .reqRead (reqRead),
    .reqAddr (reqAddr),
    .reqSize (reqSize),
    .reqWdata(reqWdata),
    .miso    (miso),
    .mosi    (mosi),
    .rdData  (rdData)
  );

  assign busy = busyI;

endmodule

// File: rtl/adc_cmd_spi_chk.sv
module adc_cmd_spi_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic err,
  input logic sclk,
  input logic csN,
  input logic mosi
);

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk);                                            // R4

  AST_SCLK_FALL_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> busy);                                      // R4

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclk) |-> $stable(mosi));                          // R4

  AST_CS_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !csN);                                             // R5

  AST_CS_FALL_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $rose(busy));                                // R5

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (done && !busy && $stable(csN) && sclk));           // R7

  AST_DONE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);                                            // R8

  AST_FRAME_END_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && !err));                            // R8

endmodule

bind adc_cmd_spi adc_cmd_spi_chk i_chk (
  .clk (clk),
  .rstN(rstN),
  .busy(busy),
  .done(done),
  .err (err),
  .sclk(sclk),
  .csN (csN),
  .mosi(mosi)
);

// File: tb/test_adc_cmd_spi.sv
`timescale 1ns/1ps
module test_adc_cmd_spi;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqRead = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [23:0] reqWdata = '0;
  logic        reqHoldCs = 1'b0;
  logic        miso = 1'b0;
  logic        busy, done, err, sclk, csN, mosi;
  logic [23:0] rdData;

  adc_cmd_spi #(.HALF_DIV(HALF)) i_adc_cmd_spi (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .reqHoldCs(reqHoldCs), .miso(miso), .busy(busy), .done(done),
    .err(err), .rdData(rdData), .sclk(sclk), .csN(csN), .mosi(mosi)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit          busy;
    bit          done;
    bit          err;
    bit          sclk;
    bit          csN;
    bit          mosi;
    logic [23:0] rd;
    string       tag;
  } exp_t;

  exp_t  expQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    lastBusy = 0;
  bit    expCsIdle = 1;
  bit    prevSclk = 1;
  logic [31:0] slvPat = '0;
  string busyTag = "R8";

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    if (expQ.size() > 0) e = expQ.pop_front();
    else begin
      e.busy = 0; e.done = 0; e.err = 0; e.sclk = 1;
      e.csN = expCsIdle; e.mosi = 0; e.rd = '0; e.tag = "R2";
    end
    chk(busyTag, "busy", 24'(busy), 24'(e.busy));
    chk(busyTag, "done", 24'(done), 24'(e.done));
    chk("R7", "err", 24'(err), 24'(e.err));
    chk("R4", "sclk", 24'(sclk), 24'(e.sclk));
    chk(e.csN ? "R5" : "R6", "csN", 24'(csN), 24'(e.csN));
    chk(e.tag, "mosi", 24'(mosi), 24'(e.mosi));
    if (e.done) chk("R3", "rdData", rdData, e.rd);
    lastBusy  = e.busy;
    expCsIdle = e.csN;
    reqValid  = 1'b0;
    // converter model: next bit on each falling sclk within the frame
    if (!csN && !sclk && prevSclk) begin
      miso   = slvPat[31];
      slvPat = {slvPat[30:0], 1'b0};
    end
    prevSclk = sclk;
  endtask

  task automatic issue(bit rd, bit [2:0] addr, bit [1:0] size, bit [23:0] wdata,
                       bit hold, bit [23:0] payload, bit [7:0] junk);
    exp_t e;
    bit [31:0] stream;
    bit [23:0] mask;
    reqValid = 1'b1; reqRead = rd; reqAddr = addr; reqSize = size;
    reqWdata = wdata; reqHoldCs = hold;
    if (lastBusy) return;                     // R9: not taken
    if (size == 0) begin
      e.busy = 0; e.done = 1; e.err = 1; e.sclk = 1; e.csN = expCsIdle;
      e.mosi = 0; e.rd = '0; e.tag = "R7";
      expQ.push_back(e);
      return;
    end
    mask   = (24'h1 << (8 * size)) - 1;
    stream = {1'b0, rd, addr, 3'b000, (rd ? 24'h0 : (wdata & mask)) << (8 * (3 - size))};
    slvPat = {junk, (payload & mask) << (8 * (3 - size))};
    for (int b = 0; b < 8 * (size + 1); b++) begin
      for (int p = 0; p < 2 * HALF; p++) begin
        e.busy = 1; e.done = 0; e.err = 0; e.sclk = (p >= HALF); e.csN = 0;
        e.mosi = stream[31 - b]; e.rd = '0; e.tag = (b < 8) ? "R1" : "R2";
        expQ.push_back(e);
      end
    end
    e.busy = 0; e.done = 1; e.err = 0; e.sclk = 1; e.csN = !hold;
    e.mosi = 0; e.rd = rd ? (payload & mask) : 24'h0; e.tag = "R2";
    expQ.push_back(e);
  endtask

  task automatic drain();
    while (expQ.size() > 0) step();
    repeat (3) step();
  endtask

  // step until the done cycle of the running frame has just been compared
  task automatic toDone();
    while (expQ.size() > 1) step();
    step();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R8 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "csN", 24'(csN), 24'h1);
    chk("R10", "sclk", 24'(sclk), 24'h1);
    chk("R10", "busy", 24'(busy), 24'h0);
    chk("R10", "done", 24'(done), 24'h0);
    chk("R10", "err", 24'(err), 24'h0);
    chk("R10", "mosi", 24'(mosi), 24'h0);
    chk("R10", "rdData", rdData, 24'h0);
    rstN = 1'b1;
    repeat (2) step();

    // R1 R2: 16-bit write to address 1
    issue(0, 3'd1, 2'd2, 24'h77A5C3, 0, 24'h0, 8'h00);
    drain();
    // R3: 24-bit read at address 3, busy bits during command
    issue(1, 3'd3, 2'd3, 24'h0, 0, 24'hC35A96, 8'hFF);
    drain();
    // R2: 8-bit write ignores upper write data
    issue(0, 3'd5, 2'd1, 24'hABCD12, 0, 24'h0, 8'h00);
    drain();
    // R6: 8-bit read with hold, chip select stays low while idle
    issue(1, 3'd4, 2'd1, 24'h0, 1, 24'hFFFF5B, 8'hA5);
    drain();
    // R7 while chip select is held low
    issue(0, 3'd2, 2'd0, 24'h123456, 0, 24'h0, 8'h00);
    drain();
    // R5: frame without hold releases chip select
    issue(0, 3'd2, 2'd2, 24'h00F00F, 0, 24'h0, 8'h00);
    drain();
    // R7 with chip select high
    issue(1, 3'd0, 2'd0, 24'h0, 1, 24'h0, 8'h00);
    drain();
    // R9: request during a frame is ignored
    issue(1, 3'd6, 2'd2, 24'h0, 0, 24'h8001, 8'h3C);
    repeat (10) step();
    busyTag = "R9";
    issue(0, 3'd7, 2'd3, 24'hFFFFFF, 1, 24'h0, 8'h00);
    step();
    toDone();
    // R9: request in the done cycle is accepted
    issue(0, 3'd7, 2'd3, 24'hFEDCBA, 0, 24'h0, 8'h00);
    toDone();
    busyTag = "R8";
    issue(1, 3'd3, 2'd2, 24'h0, 0, 24'h6E21, 8'h81);
    drain();
    // R8 back-to-back rejections
    issue(0, 3'd1, 2'd0, 24'h0, 0, 24'h0, 8'h00);
    step();
    issue(0, 3'd1, 2'd0, 24'h0, 0, 24'h0, 8'h00);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule